// File: doc/BRIEF.md
# Double-Buffered Serial Port DMA Engine

This block moves bytes between memory and a serial port core. It has two independent channels. The transmit channel reads memory and offers bytes to the serial core. The receive channel takes bytes from the serial core and writes them to memory. Each channel owns two buffers, called A and B, and each buffer is described by an inclusive start and end byte address. While one buffer is being drained or filled, software can prepare the other one, so a long stream never stalls on software.

Software programs eight address registers through a small write port. It then arms a buffer by writing a 1 to that buffer's bit in a six-bit control word. When the buffer is armed, its addresses are copied into working registers, so the programming registers are free again at once. The same control bits read back as busy flags. Hardware clears each flag when its buffer finishes. A per-channel abort bit stops a channel at once and drops all of its work.

The memory read port is combinational and single-beat: the engine drives an address and the byte is expected back in the same cycle. The receive side writes one byte per accepted beat.

Top module: `serial_dma_pingpong`

## Requirements
- R1: After reset, the control readback is 0, `txValid` is 0, `rxReady` is 0 and `memWrEn` is 0.
- R2: The control bits are: bit 5 transmit abort, bit 4 receive abort, bit 3 arm transmit B, bit 2 arm transmit A, bit 1 arm receive B, bit 0 arm receive A. After a write that sets an arm bit, that bit reads 1 from the next cycle on. The buffer then moves every address from start to end, inclusive and ascending, one byte per handshake. The bit reads 0 from the edge on which the byte at the end address is transferred.
- R3: A 0 written to an arm bit changes nothing. A status bit only rises after a write that carried a 1 in that position.
- R4: When both buffers of a channel are armed by the same write, buffer A is transferred first and buffer B second.
- R5: When a buffer finishes and the other buffer of the channel is pending, the next handshake can take place on the very next cycle. Arming from idle costs exactly one cycle with status set and no byte offered.
- R6: A buffer armed while the other buffer of its channel is active waits, and it starts when the active one finishes. Buffers are served in the order they were armed.
- R7: Writing 1 to an abort bit makes that bit read 1 for exactly one cycle and 0 afterwards. In that same cycle, both of the channel's arm/status bits read 0 and the channel offers or accepts no bytes.
- R8: While neither receive buffer is pending or active, `rxReady` is 0 and no memory write occurs, whatever `rxValid` does.
- R9: The receive channel writes each byte accepted with `rxValid` and `rxReady` to the current buffer's next ascending address, with `memWrEn` high in the same cycle.
- R10: While `txValid` is 1 and `txReady` is 0, `memRdAddr` and `txByte` hold their values into the next cycle (unless an abort is written).
- R11: Writing 1 to the arm bit of a buffer whose status already reads 1 is ignored. Neither that buffer's addresses nor its progress change.
- R12: The address registers are selected by `regSel` = {transmit, buffer B, end}. For example, 3'b000 is receive A start and 3'b111 is transmit B end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 6 | Control word write data (arm and abort bits) |
| ctrlRdData | output | 6 | Control readback: abort flags and busy status |
| regWrEn | input | 1 | Address register write strobe |
| regSel | input | 3 | Address register select {transmit, B, end} |
| regWrData | input | AW | Address register write data |
| memRdAddr | output | AW | Memory read address for the transmit channel |
| memRdData | input | 8 | Memory read data, valid in the same cycle |
| txValid | output | 1 | Transmit byte valid toward serial core |
| txReady | input | 1 | Serial core accepts the transmit byte |
| txByte | output | 8 | Transmit byte |
| rxValid | input | 1 | Serial core offers a received byte |
| rxReady | output | 1 | Receive channel can take a byte |
| rxByte | input | 8 | Received byte |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | AW | Memory write address |
| memWrData | output | 8 | Memory write data |

## Verification
Each write to the control word takes effect on the clock edge that samples it. The status bit is visible in the cycle after that edge, and so is the abort flag with its cleared status. The first byte of a buffer armed from idle is offered one cycle later still. Each handshake moves the address on the following edge. A finished buffer's status drops on the edge of its last handshake.

Inputs change on falling edges, and all outputs are sampled a quarter period later. So each sample shows the values that the next rising edge will act on. A monitor pops the expected address and byte for every handshake it sees. A cycle counter measures how many idle-but-busy cycles occur, which checks the gapless switch between buffers.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_RX  = 0;
  localparam int CH_TX  = 1;

  // strobes from a channel sequencer to the address datapath
  typedef struct packed {
    logic latchA;  // copy programmed A addresses into working set
    logic latchB;
    logic startA;  // point the cursor at A start
    logic startB;
    logic step;    // advance the cursor by one byte
    logic selB;    // buffer currently owning the cursor
  } chan_strobe_t;
endpackage

// File: rtl/sdma_chan_ctrl.sv
module sdma_chan_ctrl
  import sdma_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrLoadA,
  input  logic         wrLoadB,
  input  logic         wrAbort,
  input  logic         fire,
  input  logic         atEnd,
  output chan_strobe_t str,
  output logic         pendA,
  output logic         pendB,
  output logic         rstFlag,
  output logic         active
);
  logic curB;
  logic loadA, loadB, finish;

  always_comb begin
    loadA  = wrLoadA && !pendA && !wrAbort;
    loadB  = wrLoadB && !pendB && !wrAbort;
    finish = active && fire && atEnd;
    str        = '0;
    str.latchA = loadA;
    str.latchB = loadB;
    str.selB   = curB;
    str.step   = active && fire && !atEnd;
    if (!active) begin
      // A wins when both are waiting
      str.startA = pendA;
      str.startB = !pendA && pendB;
    end else if (finish) begin
      // hand over to the other buffer with no empty slot
      str.startA = curB && pendA;
      str.startB = !curB && pendB;
    end
    if (wrAbort) begin
      str.startA = 1'b0;
      str.startB = 1'b0;
      str.step   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendA   <= 1'b0;
      pendB   <= 1'b0;
      active  <= 1'b0;
      curB    <= 1'b0;
      rstFlag <= 1'b0;
    end else begin
      rstFlag <= wrAbort;
      if (wrAbort) begin
        pendA  <= 1'b0;
        pendB  <= 1'b0;
        active <= 1'b0;
        curB   <= 1'b0;
      end else begin
        pendA <= (pendA && !(finish && !curB)) || loadA;
        pendB <= (pendB && !(finish && curB)) || loadB;
        if (str.startA || str.startB) begin
          active <= 1'b1;
          curB   <= str.startB;
        end else if (finish) begin
          active <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sdma_datapath.sv
module sdma_datapath
  import sdma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrEn,
  input  logic [2:0]      regSel,
  input  logic [AW-1:0]   regWrData,
  input  chan_strobe_t    str     [NUM_CH],
  output logic [AW-1:0]   curAddr [NUM_CH],
  output logic            atEnd   [NUM_CH]
);
  localparam int NUM_REG = 4 * NUM_CH;

  logic [AW-1:0] progReg [NUM_REG];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REG; i++) progReg[i] <= '0;
    end else if (regWrEn) begin
      progReg[regSel] <= regWrData;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [AW-1:0] startAQ, endAQ, startBQ, endBQ, addrQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        startAQ <= '0;
        endAQ   <= '0;
        startBQ <= '0;
        endBQ   <= '0;
        addrQ   <= '0;
      end else begin
        if (str[ch].latchA) begin
          startAQ <= progReg[ch*4 + 0];
          endAQ   <= progReg[ch*4 + 1];
        end
        if (str[ch].latchB) begin
          startBQ <= progReg[ch*4 + 2];
          endBQ   <= progReg[ch*4 + 3];
        end
        if (str[ch].startA)      addrQ <= startAQ;
        else if (str[ch].startB) addrQ <= startBQ;
        else if (str[ch].step)   addrQ <= addrQ + 1'b1;
      end
    end

    assign curAddr[ch] = addrQ;
    assign atEnd[ch]   = (addrQ == (str[ch].selB ? endBQ : endAQ));
  end
endmodule

// File: rtl/serial_dma_pingpong.sv
module serial_dma_pingpong
  import sdma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlWrEn,
  input  logic [5:0]    ctrlWrData,
  output logic [5:0]    ctrlRdData,
  input  logic          regWrEn,
  input  logic [2:0]    regSel,
  input  logic [AW-1:0] regWrData,
  output logic [AW-1:0] memRdAddr,
  input  logic [7:0]    memRdData,
  output logic          txValid,
  input  logic          txReady,
  output logic [7:0]    txByte,
  input  logic          rxValid,
  output logic          rxReady,
  input  logic [7:0]    rxByte,
  output logic          memWrEn,
  output logic [AW-1:0] memWrAddr,
  output logic [7:0]    memWrData
);
  chan_strobe_t  str     [NUM_CH];
  logic [AW-1:0] curAddr [NUM_CH];
  logic          atEnd   [NUM_CH];
  logic [NUM_CH-1:0] pendA, pendB, rstFlag, active, fire;

  // control word layout: {txAbort, rxAbort, txB, txA, rxB, rxA}
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_seq
    sdma_chan_ctrl i_ctrl (
      .clk     (clk),
      .rstN    (rstN),
      .wrLoadA (ctrlWrEn && ctrlWrData[ch*2]),
      .wrLoadB (ctrlWrEn && ctrlWrData[ch*2+1]),
      .wrAbort (ctrlWrEn && ctrlWrData[4+ch]),
      .fire    (fire[ch]),
      .atEnd   (atEnd[ch]),
      .str     (str[ch]),
      .pendA   (pendA[ch]),
      .pendB   (pendB[ch]),
      .rstFlag (rstFlag[ch]),
      .active  (active[ch])
    );
  end

  sdma_datapath #(.AW(AW)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .str       (str),
    .curAddr   (curAddr),
    .atEnd     (atEnd)
  );

  assign ctrlRdData = {rstFlag[CH_TX], rstFlag[CH_RX],
                       pendB[CH_TX], pendA[CH_TX], pendB[CH_RX], pendA[CH_RX]};

  assign txValid     = active[CH_TX];
  assign memRdAddr   = curAddr[CH_TX];
  assign txByte      = memRdData;
  assign fire[CH_TX] = txValid && txReady;

  assign rxReady     = active[CH_RX];
  assign memWrEn     = rxValid && active[CH_RX];
  assign memWrAddr   = curAddr[CH_RX];
  assign memWrData   = rxByte;
  assign fire[CH_RX] = memWrEn;
endmodule

// File: rtl/sdma_checker.sv
module sdma_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          ctrlWrEn,
  input logic [5:0]    ctrlWrData,
  input logic [5:0]    ctrlRdData,
  input logic [AW-1:0] memRdAddr,
  input logic          txValid,
  input logic          txReady,
  input logic [7:0]    txByte,
  input logic          rxReady,
  input logic          memWrEn
);
  AST_TX_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (ctrlRdData[3] || ctrlRdData[2])); // R2

  AST_STATUS_RISES_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlRdData[2]) |-> $past(ctrlWrEn && ctrlWrData[2])); // R3

  AST_TX_ABORT_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdData[5] && !(ctrlWrEn && ctrlWrData[5]) |=> !ctrlRdData[5]); // R7

  AST_RX_ABORT_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdData[4] && !(ctrlWrEn && ctrlWrData[4]) |=> !ctrlRdData[4]); // R7

  AST_ABORT_EMPTIES_TX: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdData[5] |-> (ctrlRdData[3:2] == 2'b00 && !txValid)); // R7

  AST_RX_DROP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rxReady |-> !memWrEn); // R8

  AST_TX_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady && !(ctrlWrEn && ctrlWrData[5])
    |=> txValid && $stable(memRdAddr) && $stable(txByte)); // R10
endmodule

bind serial_dma_pingpong sdma_checker #(.AW(AW)) i_sdma_checker (
  .clk        (clk),
  .rstN       (rstN),
  .ctrlWrEn   (ctrlWrEn),
  .ctrlWrData (ctrlWrData),
  .ctrlRdData (ctrlRdData),
  .memRdAddr  (memRdAddr),
  .txValid    (txValid),
  .txReady    (txReady),
  .txByte     (txByte),
  .rxReady    (rxReady),
  .memWrEn    (memWrEn)
);

// File: tb/test_serial_dma_pingpong.sv
`timescale 1ns/1ps
module test_serial_dma_pingpong;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic          ctrlWrEn;
  logic [5:0]    ctrlWrData;
  logic [5:0]    ctrlRdData;
  logic          regWrEn;
  logic [2:0]    regSel;
  logic [AW-1:0] regWrData;
  logic [AW-1:0] memRdAddr;
  logic [7:0]    memRdData;
  logic          txValid, txReady;
  logic [7:0]    txByte;
  logic          rxValid, rxReady;
  logic [7:0]    rxByte;
  logic          memWrEn;
  logic [AW-1:0] memWrAddr;
  logic [7:0]    memWrData;

  int errors = 0;
  int checks = 0;
  int idleBusy = 0;
  logic [AW-1:0] expTx [$];
  logic [AW+7:0] expRx [$];
  string txTag = "R2";

  always #10 clk = ~clk;

  // memory model: byte is a fixed function of address
  assign memRdData = memRdAddr[7:0] ^ 8'h5A;

  serial_dma_pingpong #(.AW(AW)) i_serial_dma_pingpong (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic setReg(input logic [2:0] sel, input logic [AW-1:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic ctrlWrite(input logic [5:0] val);
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrData = val;
    @(negedge clk);
    ctrlWrEn = 1'b0; ctrlWrData = '0;
  endtask

  task automatic pushTx(input int first, input int last);
    for (int a = first; a <= last; a++) expTx.push_back(AW'(a));
  endtask

  task automatic drainTx(input string req);
    int n = 0;
    while (expTx.size() != 0 && n < 200) begin
      @(negedge clk); n++;
    end
    @(negedge clk);
    check(expTx.size() == 0, req, expTx.size(), 0);
    check(ctrlRdData[3:2] == 2'b00, {req, " status clears"}, ctrlRdData[3:2], 0);
  endtask

  // monitor samples a quarter period after inputs change
  always @(negedge clk) begin
    #5;
    if (rstN) begin
      if (ctrlRdData[3:2] != 2'b00 && txReady && !txValid) idleBusy++;
      if (txValid && txReady) begin
        if (expTx.size() == 0) check(1'b0, {txTag, " unexpected tx"}, memRdAddr, 0);
        else begin
          logic [AW-1:0] e;
          e = expTx.pop_front();
          check(memRdAddr == e, {txTag, " tx address"}, memRdAddr, e);
          check(txByte == (e[7:0] ^ 8'h5A), {txTag, " tx byte"}, txByte, e[7:0] ^ 8'h5A);
        end
      end
      if (memWrEn) begin
        if (expRx.size() == 0) check(1'b0, "R8 unexpected memory write", memWrAddr, 0);
        else begin
          logic [AW+7:0] e;
          e = expRx.pop_front();
          check({memWrAddr, memWrData} == e, "R9 rx write", {memWrAddr, memWrData}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    logic [AW-1:0] held;
    rstN = 1'b0; ctrlWrEn = 0; ctrlWrData = '0; regWrEn = 0; regSel = '0; regWrData = '0;
    txReady = 1'b0; rxValid = 1'b0; rxByte = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(ctrlRdData == 6'd0, "R1 control readback", ctrlRdData, 0);
    check(!txValid && !rxReady && !memWrEn, "R1 outputs idle",
          {txValid, rxReady, memWrEn}, 0);

    // R3: writing zeros arms nothing
    ctrlWrite(6'b000000);
    check(ctrlRdData == 6'd0, "R3 zero write", ctrlRdData, 0);
    repeat (2) @(negedge clk);
    check(!txValid && !rxReady, "R3 no activity", {txValid, rxReady}, 0);

    // R2/R12: single transmit buffer A, 0x10..0x13
    setReg(3'b100, 16'h0010); setReg(3'b101, 16'h0013);
    txReady = 1'b1;
    pushTx(16'h10, 16'h13);
    ctrlWrite(6'b000100);
    check(ctrlRdData[2] == 1'b1, "R2 status after arm", ctrlRdData, 6'b000100);
    drainTx("R2");

    // R4/R5: arm A and B together, A first, no gap in between
    txTag = "R4";
    setReg(3'b100, 16'h0020); setReg(3'b101, 16'h0022);
    setReg(3'b110, 16'h0030); setReg(3'b111, 16'h0031);
    pushTx(16'h20, 16'h22); pushTx(16'h30, 16'h31);
    base = idleBusy;
    ctrlWrite(6'b001100);
    drainTx("R4");
    check(idleBusy - base == 1, "R5 idle slots", idleBusy - base, 1);

    // R6: B armed, then A while B is active
    txTag = "R6";
    setReg(3'b110, 16'h0040); setReg(3'b111, 16'h0043);
    setReg(3'b100, 16'h0050); setReg(3'b101, 16'h0051);
    pushTx(16'h40, 16'h43); pushTx(16'h50, 16'h51);
    ctrlWrite(6'b001000);
    ctrlWrite(6'b000100);
    drainTx("R6");

    // R10/R11: stall, then try to re-arm a busy buffer
    txTag = "R11";
    txReady = 1'b0;
    setReg(3'b100, 16'h0060); setReg(3'b101, 16'h0062);
    pushTx(16'h60, 16'h62);
    ctrlWrite(6'b000100);
    @(negedge clk);
    held = memRdAddr;
    repeat (3) @(negedge clk);
    check(txValid && memRdAddr == held, "R10 hold on stall", memRdAddr, held);
    setReg(3'b100, 16'h0070); setReg(3'b101, 16'h0075);
    ctrlWrite(6'b000100);
    check(memRdAddr == 16'h0060, "R11 busy re-arm ignored", memRdAddr, 16'h0060);
    txReady = 1'b1;
    drainTx("R11");

    // R7: abort transmit mid-buffer
    txReady = 1'b0;
    setReg(3'b100, 16'h0080); setReg(3'b101, 16'h008F);
    ctrlWrite(6'b000100);
    repeat (2) @(negedge clk);
    ctrlWrite(6'b100000);
    check(ctrlRdData == 6'b100000, "R7 abort flag and status", ctrlRdData, 6'b100000);
    check(!txValid, "R7 no tx after abort", txValid, 0);
    @(negedge clk);
    check(ctrlRdData == 6'd0, "R7 abort self-clears", ctrlRdData, 0);
    txReady = 1'b1;
    repeat (3) @(negedge clk);
    check(!txValid, "R7 channel idle", txValid, 0);

    // R8: receive idle drops bytes
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rxValid = 1'b1; rxByte = 8'hA0 + 8'(i);
      #5;
      check(!rxReady, "R8 ready low when idle", rxReady, 0);
    end
    @(negedge clk);
    rxValid = 1'b0;

    // R9: receive buffer A, 0x0200..0x0202
    setReg(3'b000, 16'h0200); setReg(3'b001, 16'h0202);
    ctrlWrite(6'b000001);
    check(ctrlRdData[0], "R2 rx status after arm", ctrlRdData, 6'b000001);
    @(negedge clk);
    check(rxReady, "R9 ready when active", rxReady, 1);
    for (int i = 0; i < 3; i++) begin
      rxValid = 1'b1; rxByte = 8'hC0 + 8'(i);
      expRx.push_back({16'h0200 + 16'(i), 8'hC0 + 8'(i)});
      @(negedge clk);
    end
    rxValid = 1'b0;
    @(negedge clk);
    check(expRx.size() == 0, "R9 all bytes written", expRx.size(), 0);
    check(ctrlRdData[0] == 1'b0 && !rxReady, "R9 rx done", ctrlRdData, 0);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule